// File: doc/BRIEF.md
# Receive Frame Admission Controller

This block makes the per-frame decision in an Ethernet receive path. For each arriving frame it takes the byte count, the address filter verdict and the hardware-owned bit of the current receive descriptor, and decides whether the frame is stored, dropped or causes receive to stall. It raises one-cycle event pulses toward an interrupt collector and tracks whether receive is currently active.

When a frame is admitted, the block issues a store command and waits for the memory mover to report completion, with or without a bus error. It then emits the word to be written back into the descriptor: the recorded length, a good flag, a too-long flag, and the ownership bit returned to software. The data transfer and the CRC computation are done elsewhere. Only one admitted frame is outstanding at a time.

Top module: `rx_admit_ctrl`

## Requirements
- R1: A frame shorter than 14 bytes, or with length plus 4 above 65535, is dropped (`drop` pulses) with no event pulse of any kind.
- R2: Every frame that passes the size sanity check pulses `evt_len`, whatever its outcome.
- R3: A sane frame with `filter_ok` low is dropped with `evt_len` only.
- R4: The maximum-size register resets to 2048 and is loaded by `max_wr`. A filtered frame whose length plus 4 exceeds it is dropped with `evt_big`.
- R5: A frame whose length plus 4 exceeds 1518 is dropped with `evt_long` while `allow_long` is low. While `allow_long` is high, it is stored and its status word has bit 17 set.
- R6: A frame that passes the length checks while `desc_owned` is low pulses `evt_unavail` and `drop`, and clears `rx_active`.
- R7: The recorded length in status bits [15:0] is the frame length plus 4 when `strip_crc` is low, and the frame length alone when it is high. Both controls are sampled when the frame is accepted.
- R8: A completion without bus error pulses `desc_wr` and `evt_good` one cycle after `xfer_done`. The status word has bit 16 (good) set and bit 31 (owner) clear.
- R9: A completion with `bus_err` pulses `desc_wr` and `evt_berr` with an all-zero status word, so ownership still returns to software.
- R10: `rx_active` resets low and clears whenever `rx_en` is low. It sets after a rising `rx_en` or an `rx_demand` pulse while `rx_en` is high. A demand beats a halt in the same cycle. Frames offered while inactive are ignored.
- R11: The checks apply in the order size sanity, filter, maximum size, long frame, descriptor owner. Only the first failing check raises its event, and at most one of `store_go` and `drop` pulses.
- R12: From `store_go` until the completion, `rx_ready` is low and offered frames are ignored. All decision outputs appear one cycle after the frame is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable level |
| rx_demand | input | 1 | Receive demand strobe, re-arms after a stall |
| allow_long | input | 1 | Keep frames longer than 1518 bytes |
| strip_crc | input | 1 | Record length without the 4 CRC bytes |
| max_wr | input | 1 | Load the maximum-size register |
| max_din | input | 16 | Value for the maximum-size register |
| frame_valid | input | 1 | Frame presented this cycle |
| frame_len | input | 17 | Frame byte count, without CRC |
| filter_ok | input | 1 | Address filter accepts the frame |
| desc_owned | input | 1 | Current descriptor is owned by hardware |
| xfer_done | input | 1 | Memory transfer of the stored frame finished |
| bus_err | input | 1 | The finished transfer hit a bus error |
| rx_ready | output | 1 | A frame presented now would be evaluated |
| rx_active | output | 1 | Receive-active flag |
| store_go | output | 1 | Start storing the frame |
| drop | output | 1 | Frame discarded |
| evt_len | output | 1 | Length-received event |
| evt_big | output | 1 | Frame exceeds the programmed maximum |
| evt_long | output | 1 | Frame exceeds 1518 bytes and is not allowed |
| evt_unavail | output | 1 | Descriptor unavailable, receive halted |
| desc_wr | output | 1 | Write `desc_status` back to the descriptor |
| desc_status | output | 32 | Descriptor status word |
| evt_good | output | 1 | Frame received good |
| evt_berr | output | 1 | Receive bus error |

## Verification
The bench exercises the length boundaries on both sides: 13 and 14 bytes, the top of the sanity range, exactly the programmed maximum, and exactly 1518 including CRC. An off-by-one comparison would store or drop the wrong one of each pair. Frames that fail several checks at once expose a wrong priority, which would raise the wrong event or several events. The descriptor-unowned stall is followed by frames that must be ignored and then by a demand strobe. This catches a design that keeps accepting frames or never re-arms. Completions with and without bus error, each under both CRC settings, expose a wrong recorded length or a status word that keeps the owner bit.

// File: rtl/rx_adm_pkg.sv
package rx_adm_pkg;
  typedef enum logic [2:0] {
    V_SILENT = 3'd0,
    V_FILTER = 3'd1,
    V_BIG    = 3'd2,
    V_LONG   = 3'd3,
    V_HALT   = 3'd4,
    V_STORE  = 3'd5
  } verdict_e;
endpackage

// File: rtl/rx_adm_classify.sv
module rx_adm_classify
  import rx_adm_pkg::*;
#(
  parameter int LEN_W     = 17,
  parameter int MAX_W     = 16,
  parameter int REC_W     = 16,
  parameter int MIN_LEN   = 14,
  parameter int CRC_BYTES = 4,
  parameter int STD_MAX   = 1518
) (
  input  logic [LEN_W-1:0] len,
  input  logic             filter_ok,
  input  logic             owned,
  input  logic             allow_long,
  input  logic             strip_crc,
  input  logic [MAX_W-1:0] max_len,
  output verdict_e         verdict,
  output logic             long_flag,
  output logic [REC_W-1:0] rec_len
);
  localparam int SUM_W    = LEN_W + 1;
  localparam int SANE_MAX = (1 << REC_W) - 1 - CRC_BYTES;

  logic [SUM_W-1:0] with_crc;
  logic             sane;
  logic             over_max;

  always_comb begin
    with_crc  = {1'b0, len} + SUM_W'(CRC_BYTES);
    sane      = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(SANE_MAX));
    over_max  = with_crc > SUM_W'(max_len);
    long_flag = with_crc > SUM_W'(STD_MAX);
    rec_len   = strip_crc ? len[REC_W-1:0] : with_crc[REC_W-1:0];
    if (!sane)                        verdict = V_SILENT;
    else if (!filter_ok)              verdict = V_FILTER;
    else if (over_max)                verdict = V_BIG;
    else if (long_flag && !allow_long) verdict = V_LONG;
    else if (!owned)                  verdict = V_HALT;
    else                              verdict = V_STORE;
  end
endmodule

// File: rtl/rx_adm_active.sv
module rx_adm_active (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic demand,
  input  logic halt,
  output logic active
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      active <= 1'b0;
    end else begin
      en_q <= rx_en;
      if (!rx_en)                  active <= 1'b0;
      else if (!en_q || demand)    active <= 1'b1;
      else if (halt)               active <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_adm_status.sv
module rx_adm_status #(
  parameter int REC_W    = 16,
  parameter int STAT_W   = 32,
  parameter int GOOD_BIT = 16,
  parameter int LONG_BIT = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [REC_W-1:0]  rec_len,
  input  logic              long_flag,
  input  logic              xfer_done,
  input  logic              bus_err,
  output logic              pending,
  output logic              desc_wr,
  output logic [STAT_W-1:0] status,
  output logic              evt_good,
  output logic              evt_berr
);
  logic [REC_W-1:0]  len_q;
  logic              long_q;
  logic [STAT_W-1:0] good_word;
  logic              finish;

  assign finish = xfer_done && pending;

  always_comb begin
    good_word              = '0;
    good_word[REC_W-1:0]   = len_q;
    good_word[GOOD_BIT]    = 1'b1;
    good_word[LONG_BIT]    = long_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      len_q    <= '0;
      long_q   <= 1'b0;
      desc_wr  <= 1'b0;
      status   <= '0;
      evt_good <= 1'b0;
      evt_berr <= 1'b0;
    end else begin
      desc_wr  <= finish;
      evt_good <= finish && !bus_err;
      evt_berr <= finish && bus_err;
      if (finish) begin
        pending <= 1'b0;
        status  <= bus_err ? '0 : good_word;
      end else if (capture) begin
        pending <= 1'b1;
        len_q   <= rec_len;
        long_q  <= long_flag;
      end
    end
  end
endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl
  import rx_adm_pkg::*;
#(
  parameter int LEN_W     = 17,
  parameter int MAX_W     = 16,
  parameter int REC_W     = 16,
  parameter int STAT_W    = 32,
  parameter int MIN_LEN   = 14,
  parameter int CRC_BYTES = 4,
  parameter int STD_MAX   = 1518,
  parameter int MAX_RESET = 2048,
  parameter int GOOD_BIT  = 16,
  parameter int LONG_BIT  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rx_demand,
  input  logic              allow_long,
  input  logic              strip_crc,
  input  logic              max_wr,
  input  logic [MAX_W-1:0]  max_din,
  input  logic              frame_valid,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              filter_ok,
  input  logic              desc_owned,
  input  logic              xfer_done,
  input  logic              bus_err,
  output logic              rx_ready,
  output logic              rx_active,
  output logic              store_go,
  output logic              drop,
  output logic              evt_len,
  output logic              evt_big,
  output logic              evt_long,
  output logic              evt_unavail,
  output logic              desc_wr,
  output logic [STAT_W-1:0] desc_status,
  output logic              evt_good,
  output logic              evt_berr
);
  logic [MAX_W-1:0] max_q;
  verdict_e         verdict;
  logic             long_flag;
  logic [REC_W-1:0] rec_len;
  logic             pending;
  logic             accept;
  logic             halt;

  assign accept   = frame_valid && rx_active && !pending;
  assign halt     = accept && (verdict == V_HALT);
  assign rx_ready = rx_active && !pending;

  rx_adm_classify #(
    .LEN_W(LEN_W), .MAX_W(MAX_W), .REC_W(REC_W), .MIN_LEN(MIN_LEN),
    .CRC_BYTES(CRC_BYTES), .STD_MAX(STD_MAX)
  ) u_cls (
    .len(frame_len), .filter_ok(filter_ok), .owned(desc_owned),
    .allow_long(allow_long), .strip_crc(strip_crc), .max_len(max_q),
    .verdict(verdict), .long_flag(long_flag), .rec_len(rec_len)
  );

  rx_adm_active u_act (
    .clk(clk), .rst(rst), .rx_en(rx_en), .demand(rx_demand),
    .halt(halt), .active(rx_active)
  );

  rx_adm_status #(
    .REC_W(REC_W), .STAT_W(STAT_W), .GOOD_BIT(GOOD_BIT), .LONG_BIT(LONG_BIT)
  ) u_st (
    .clk(clk), .rst(rst), .capture(accept && (verdict == V_STORE)),
    .rec_len(rec_len), .long_flag(long_flag), .xfer_done(xfer_done),
    .bus_err(bus_err), .pending(pending), .desc_wr(desc_wr),
    .status(desc_status), .evt_good(evt_good), .evt_berr(evt_berr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q       <= MAX_W'(MAX_RESET);
      store_go    <= 1'b0;
      drop        <= 1'b0;
      evt_len     <= 1'b0;
      evt_big     <= 1'b0;
      evt_long    <= 1'b0;
      evt_unavail <= 1'b0;
    end else begin
      if (max_wr) max_q <= max_din;
      store_go    <= accept && (verdict == V_STORE);
      drop        <= accept && (verdict != V_STORE);
      evt_len     <= accept && (verdict != V_SILENT);
      evt_big     <= accept && (verdict == V_BIG);
      evt_long    <= accept && (verdict == V_LONG);
      evt_unavail <= halt;
    end
  end
endmodule

// File: rtl/rx_admit_chk.sv
module rx_admit_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_demand,
  input logic        rx_ready,
  input logic        rx_active,
  input logic        store_go,
  input logic        drop,
  input logic        evt_len,
  input logic        evt_big,
  input logic        evt_long,
  input logic        evt_unavail,
  input logic        desc_wr,
  input logic [31:0] desc_status,
  input logic        evt_good,
  input logic        evt_berr
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_go, drop}));
  a_r11_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_big, evt_long, evt_unavail, store_go}));
  a_r2_len_with_events: assert property (@(posedge clk) disable iff (rst)
    (evt_big || evt_long || evt_unavail || store_go) |-> evt_len);
  a_r6_halt_clears: assert property (@(posedge clk) disable iff (rst)
    (evt_unavail && !$past(rx_demand)) |-> !rx_active);
  a_r12_busy_after_store: assert property (@(posedge clk) disable iff (rst)
    store_go |-> !rx_ready);
  a_r8_one_completion: assert property (@(posedge clk) disable iff (rst)
    desc_wr |-> ($countones({evt_good, evt_berr}) == 1));
  a_r8_owner_back: assert property (@(posedge clk) disable iff (rst)
    desc_wr |-> !desc_status[31]);
  a_r9_berr_word: assert property (@(posedge clk) disable iff (rst)
    evt_berr |-> (desc_status == 32'd0));
endmodule

bind rx_admit_ctrl rx_admit_chk u_chk (
  .clk(clk), .rst(rst), .rx_demand(rx_demand), .rx_ready(rx_ready),
  .rx_active(rx_active), .store_go(store_go), .drop(drop),
  .evt_len(evt_len), .evt_big(evt_big), .evt_long(evt_long),
  .evt_unavail(evt_unavail), .desc_wr(desc_wr), .desc_status(desc_status),
  .evt_good(evt_good), .evt_berr(evt_berr)
);

// File: tb/rx_admit_ctrl_test.sv
module rx_admit_ctrl_test;
  logic clk = 0;
  logic rst = 1;
  logic rx_en = 0, rx_demand = 0, allow_long = 0, strip_crc = 0;
  logic max_wr = 0;
  logic [15:0] max_din = 0;
  logic frame_valid = 0;
  logic [16:0] frame_len = 0;
  logic filter_ok = 0, desc_owned = 0, xfer_done = 0, bus_err = 0;
  logic rx_ready, rx_active, store_go, drop, evt_len, evt_big, evt_long;
  logic evt_unavail, desc_wr, evt_good, evt_berr;
  logic [31:0] desc_status;

  always #10 clk = ~clk;

  rx_admit_ctrl uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_demand(rx_demand),
    .allow_long(allow_long), .strip_crc(strip_crc), .max_wr(max_wr),
    .max_din(max_din), .frame_valid(frame_valid), .frame_len(frame_len),
    .filter_ok(filter_ok), .desc_owned(desc_owned), .xfer_done(xfer_done),
    .bus_err(bus_err), .rx_ready(rx_ready), .rx_active(rx_active),
    .store_go(store_go), .drop(drop), .evt_len(evt_len), .evt_big(evt_big),
    .evt_long(evt_long), .evt_unavail(evt_unavail), .desc_wr(desc_wr),
    .desc_status(desc_status), .evt_good(evt_good), .evt_berr(evt_berr)
  );

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  bit m_act, m_enq, m_pend, m_long;
  int m_max, m_rec;
  bit e_go, e_drop, e_len, e_big, e_long, e_unav, e_wr, e_good, e_berr;
  int e_stat;
  string e_tag = "R11";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit ready, halt;
    int wc;
    ready = m_act && !m_pend;
    halt = 0;
    {e_go, e_drop, e_len, e_big, e_long, e_unav, e_wr, e_good, e_berr} = '0;
    if (rst) begin
      m_act = 0; m_enq = 0; m_pend = 0; m_max = 2048; m_long = 0; m_rec = 0;
      e_stat = 0; e_tag = "R10";
    end else begin
      if (frame_valid && ready) begin
        wc = int'(frame_len) + 4;
        if (frame_len < 14 || wc > 65535) begin
          e_drop = 1; e_tag = "R1";
        end else begin
          e_len = 1;
          if (!filter_ok) begin e_drop = 1; e_tag = "R3"; end
          else if (wc > m_max) begin e_drop = 1; e_big = 1; e_tag = "R4"; end
          else if (wc > 1518 && !allow_long) begin e_drop = 1; e_long = 1; e_tag = "R5"; end
          else if (!desc_owned) begin e_drop = 1; e_unav = 1; halt = 1; e_tag = "R6"; end
          else begin
            e_go = 1; m_pend = 1; e_tag = "R7";
            m_rec = strip_crc ? int'(frame_len) : wc;
            m_long = (wc > 1518);
          end
        end
      end else if (xfer_done && m_pend) begin
        m_pend = 0; e_wr = 1;
        if (bus_err) begin e_berr = 1; e_stat = 0; e_tag = "R9"; end
        else begin
          e_good = 1; e_tag = "R8";
          e_stat = m_rec | (1 << 16) | (m_long ? (1 << 17) : 0);
        end
      end
      if (!rx_en) m_act = 0;
      else if (!m_enq || rx_demand) m_act = 1;
      else if (halt) m_act = 0;
      m_enq = rx_en;
      if (max_wr) m_max = int'(max_din);
    end
  end

  always @(posedge clk) begin
    #5;
    cycles++;
    chk(store_go == e_go, e_tag, "store_go", store_go, e_go);
    chk(drop == e_drop, e_tag, "drop", drop, e_drop);
    chk(evt_len == e_len, "R2", "evt_len", evt_len, e_len);
    chk(evt_big == e_big, "R4", "evt_big", evt_big, e_big);
    chk(evt_long == e_long, "R5", "evt_long", evt_long, e_long);
    chk(evt_unavail == e_unav, "R6", "evt_unavail", evt_unavail, e_unav);
    chk(rx_active == m_act, "R10", "rx_active", rx_active, m_act);
    chk(rx_ready == (m_act && !m_pend), "R12", "rx_ready", rx_ready, m_act && !m_pend);
    chk(desc_wr == e_wr, "R8", "desc_wr", desc_wr, e_wr);
    chk(evt_good == e_good, "R8", "evt_good", evt_good, e_good);
    chk(evt_berr == e_berr, "R9", "evt_berr", evt_berr, e_berr);
    if (e_wr)
      chk(desc_status == 32'(e_stat), e_tag == "R9" ? "R9" : "R7", "desc_status",
          desc_status, e_stat);
  end

  task automatic send(input int len, input bit filt, input bit own);
    @(negedge clk);
    frame_valid = 1; frame_len = 17'(len); filter_ok = filt; desc_owned = own;
    @(negedge clk);
    frame_valid = 0;
    @(negedge clk);
  endtask

  task automatic finish_xfer(input bit err);
    @(negedge clk);
    xfer_done = 1; bus_err = err;
    @(negedge clk);
    xfer_done = 0; bus_err = 0;
    @(negedge clk);
  endtask

  task automatic pulse_demand();
    @(negedge clk); rx_demand = 1;
    @(negedge clk); rx_demand = 0;
  endtask

  task automatic set_max(input int v);
    @(negedge clk); max_wr = 1; max_din = 16'(v);
    @(negedge clk); max_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    send(64, 1, 1);               // R10 ignored while inactive
    @(negedge clk); rx_en = 1;
    repeat (2) @(negedge clk);
    send(64, 1, 1); finish_xfer(0);          // R7 R8 with CRC
    strip_crc = 1;
    send(100, 1, 1); finish_xfer(0);         // R7 stripped
    strip_crc = 0;
    send(13, 1, 1);                          // R1 short
    send(14, 1, 1); finish_xfer(0);          // R1 boundary kept
    send(65532, 1, 1);                       // R1 upper sanity
    send(65531, 1, 1);                       // R4 big
    send(60, 0, 1);                          // R3 filter
    send(2045, 1, 1);                        // R4 above 2048
    send(2044, 1, 1);                        // R5 long drop
    send(1514, 1, 1); finish_xfer(0);        // R5 exactly 1518
    send(1515, 1, 1);                        // R5 long
    allow_long = 1;
    send(2044, 1, 1); finish_xfer(0);        // R5 kept, bit 17
    allow_long = 0;
    set_max(100);
    send(97, 1, 1);                          // R4 big
    send(96, 1, 1); finish_xfer(0);          // R4 at limit
    send(200, 0, 0);                         // R11 filter before size
    send(150, 1, 0);                         // R11 size before owner
    send(80, 1, 0);                          // R6 halt
    send(80, 1, 1);                          // R10 ignored while halted
    pulse_demand();
    send(80, 1, 1);                          // R12 store
    send(70, 1, 1);                          // R12 ignored while pending
    finish_xfer(1);                          // R9 bus error
    strip_crc = 1;
    send(50, 1, 1); finish_xfer(1);          // R9 again
    send(50, 1, 1); finish_xfer(0);
    @(negedge clk); rx_en = 0;               // R10 disable
    send(50, 1, 1);
    @(negedge clk); rx_en = 1;
    repeat (2) @(negedge clk);
    send(50, 1, 1); finish_xfer(0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule